// File: doc/BRIEF.md
# Lazy Sub-request Cancellation Decoder

This block tracks one large read spread over a group of four data blocks and the four parity blocks that protect them. Each parity block holds the XOR of two neighbouring data blocks, so the eight blocks form a ring of four three-member constraints. When a read starts, the block asks the per-bank queues for all eight blocks in one go. It does not try to guess at arrival which banks will be lightly loaded.

Completions then come back in whatever order the banks finish. After each accepted completion the block works out, in the same cycle, every block that can now be rebuilt from what is already known. It uses a peeling rule. Each block that becomes derivable in this way and is still outstanding gets a one-cycle cancel strobe. Once all four data blocks are known or derivable, the block raises a done pulse and cancels everything still in flight in that same cycle. It then returns to idle.

The state machine has four states. `ST_IDLE` waits for a start. `ST_ISSUE` drives the issue strobes for one cycle. `ST_ACTIVE` accepts completions and peels. `ST_FINISH` pulses done and flushes the outstanding sub-requests. Its transitions are:
- idle to issue on start;
- issue to active unconditionally;
- active to finish on the completion that makes all data derivable;
- finish to idle unconditionally.

Top module: `lazy_cancel_dec`

## Requirements
- R1: After reset, `issue_o`, `cancel_o` and `done_o` are all zero and the block is idle.
- R2: A start sampled while idle makes `issue_o` all ones in the next cycle, for exactly one cycle. `issue_o` is zero at all other times.
- R3: A start sampled while a request is in progress has no effect. No further issue strobe appears.
- R4: Block IDs 0 to 3 name data blocks d0 to d3. ID 4+k names the parity block holding dk XOR d((k+1) mod 4).
- R5: A constraint is the set {dk, d((k+1) mod 4), parity 4+k}. A constraint with exactly one member not yet known makes that member derivable. This rule repeats within the same cycle until no constraint has exactly one unknown member.
- R6: A block that becomes derivable on an accepted completion gets a `cancel_o` bit in the next cycle, if it is still outstanding. No cancel is ever raised for a block whose completion was accepted, and `cancel_o` and `issue_o` are never set together.
- R7: `done_o` rises in the cycle after the completion that makes all four data blocks known or derivable, and lasts one cycle. In that cycle `cancel_o` covers every block still outstanding. The block is then idle again.
- R8: A completion for a block that has already been cancelled or already completed changes nothing. No cancel or done follows it.
- R9: Starting from a fresh request, completions of d0, d3 and parity 6 cancel d2 and parity 7. A further completion of parity 5 then gives done together with cancels of d1 and parity 4.
- R10: A completion that arrives while no request is active is ignored and leaves the next request unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Starts a new read when idle |
| cpl_valid_i | input | 1 | A sub-request completion is present this cycle |
| cpl_id_i | input | 3 | ID of the completed block (0 to 3 data, 4 to 7 parity) |
| issue_o | output | 8 | One bit per block; request strobe to the bank queues |
| cancel_o | output | 8 | One bit per block; withdraw strobe to the bank queues |
| done_o | output | 1 | One-cycle pulse when the read is fulfilled |

## Verification
The checker watches structural invariants on every cycle:
- issue strobes are all-or-nothing and only follow a start;
- issue and cancel strobes never overlap;
- no cancel is raised for a block already completed;
- done is a single-cycle pulse, raised only when every data block is marked known.

Whether the peeling picks the right blocks can only be shown by the bench's scenarios. The same holds for the cycle in which each cancel lands and for the flush of outstanding blocks at fulfilment. The bench runs a directed worked example and then sweeps hundreds of pseudo-random completion orders, including repeats and late completions of cancelled blocks, against a fixed-point model of the constraint ring.

// File: rtl/lcd_pkg.sv
package lcd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ISSUE  = 2'd1,
        ST_ACTIVE = 2'd2,
        ST_FINISH = 2'd3
    } lcd_state_e;
endpackage

// File: rtl/lcd_peel.sv
// Combinational peeling over the parity ring: repeats the single-unknown rule
// for as many passes as there are blocks, which is enough to reach the fixed point.
module lcd_peel #(
    parameter int NDATA = 4
) (
    input  logic [2*NDATA-1:0] known_i,
    output logic [2*NDATA-1:0] known_o
);
    localparam int NBLK  = 2 * NDATA;
    localparam int NPASS = NBLK;

    logic [NBLK-1:0] cur;
    logic [NBLK-1:0] nxt;

    always_comb begin
        cur = known_i;
        nxt = known_i;
        for (int p = 0; p < NPASS; p++) begin
            nxt = cur;
            for (int j = 0; j < NDATA; j++) begin
                if (({1'b0, ~cur[j]} + {1'b0, ~cur[(j + 1) % NDATA]} +
                     {1'b0, ~cur[NDATA + j]}) == 2'd1) begin
                    nxt[j]                 = 1'b1;
                    nxt[(j + 1) % NDATA]   = 1'b1;
                    nxt[NDATA + j]         = 1'b1;
                end
            end
            cur = nxt;
        end
        known_o = cur;
    end
endmodule

// File: rtl/lcd_track.sv
// Per-request bookkeeping of completed, known and outstanding blocks.
module lcd_track #(
    parameter int NDATA = 4,
    parameter int IDW   = $clog2(2 * NDATA)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_i,
    input  logic                 clr_i,
    input  logic                 take_i,
    input  logic [IDW-1:0]       id_i,
    output logic                 pend_hit_o,
    output logic                 data_done_o,
    output logic [2*NDATA-1:0]   got_q,
    output logic [2*NDATA-1:0]   known_q,
    output logic [2*NDATA-1:0]   pend_q,
    output logic [2*NDATA-1:0]   cancel_q
);
    localparam int NBLK = 2 * NDATA;

    logic [NBLK-1:0] hit;
    logic [NBLK-1:0] seed;
    logic [NBLK-1:0] closed;
    logic [NBLK-1:0] fresh;

    always_comb begin
        hit        = '0;
        hit[id_i]  = 1'b1;
        seed       = known_q | hit;
        fresh      = closed & ~seed;
        pend_hit_o = pend_q[id_i];
        data_done_o = take_i & (&closed[NDATA-1:0]);
    end

    lcd_peel #(.NDATA(NDATA)) peel_i (
        .known_i (seed),
        .known_o (closed)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            got_q    <= '0;
            known_q  <= '0;
            pend_q   <= '0;
            cancel_q <= '0;
        end else begin
            cancel_q <= '0;
            if (load_i) begin
                got_q   <= '0;
                known_q <= '0;
                pend_q  <= '1;
            end else if (clr_i) begin
                got_q   <= '0;
                known_q <= '0;
                pend_q  <= '0;
            end else if (take_i) begin
                got_q    <= got_q | hit;
                known_q  <= closed;
                pend_q   <= pend_q & ~hit & ~fresh;
                cancel_q <= fresh & pend_q;
            end
        end
    end
endmodule

// File: rtl/lcd_fsm.sv
// Request sequencing: one process for the state register, one for outputs.
module lcd_fsm #(
    parameter int NDATA = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               cpl_valid_i,
    input  logic               pend_hit_i,
    input  logic               data_done_i,
    input  logic [2*NDATA-1:0] pend_q_i,
    input  logic [2*NDATA-1:0] cancel_q_i,
    output logic               load_o,
    output logic               clr_o,
    output logic               take_o,
    output logic [2*NDATA-1:0] issue_o,
    output logic [2*NDATA-1:0] cancel_o,
    output logic               done_o
);
    import lcd_pkg::*;

    lcd_state_e state_q;
    lcd_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        load_o   = 1'b0;
        clr_o    = 1'b0;
        take_o   = 1'b0;
        issue_o  = '0;
        cancel_o = '0;
        done_o   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    load_o  = 1'b1;
                    state_d = ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                issue_o = '1;
                state_d = ST_ACTIVE;
            end
            ST_ACTIVE: begin
                cancel_o = cancel_q_i;
                take_o   = cpl_valid_i & pend_hit_i;
                if (data_done_i) state_d = ST_FINISH;
            end
            ST_FINISH: begin
                done_o   = 1'b1;
                cancel_o = cancel_q_i | pend_q_i;
                clr_o    = 1'b1;
                state_d  = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/lazy_cancel_dec.sv
module lazy_cancel_dec #(
    parameter int NDATA = 4,
    parameter int NBLK  = 2 * NDATA,
    parameter int IDW   = $clog2(2 * NDATA)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic            cpl_valid_i,
    input  logic [IDW-1:0]  cpl_id_i,
    output logic [NBLK-1:0] issue_o,
    output logic [NBLK-1:0] cancel_o,
    output logic            done_o
);
    logic            load_w;
    logic            clr_w;
    logic            take_w;
    logic            pend_hit_w;
    logic            data_done_w;
    logic [NBLK-1:0] got_w;
    logic [NBLK-1:0] known_w;
    logic [NBLK-1:0] pend_w;
    logic [NBLK-1:0] cancel_w;

    lcd_track #(.NDATA(NDATA), .IDW(IDW)) track_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load_w),
        .clr_i       (clr_w),
        .take_i      (take_w),
        .id_i        (cpl_id_i),
        .pend_hit_o  (pend_hit_w),
        .data_done_o (data_done_w),
        .got_q       (got_w),
        .known_q     (known_w),
        .pend_q      (pend_w),
        .cancel_q    (cancel_w)
    );

    lcd_fsm #(.NDATA(NDATA)) fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .cpl_valid_i (cpl_valid_i),
        .pend_hit_i  (pend_hit_w),
        .data_done_i (data_done_w),
        .pend_q_i    (pend_w),
        .cancel_q_i  (cancel_w),
        .load_o      (load_w),
        .clr_o       (clr_w),
        .take_o      (take_w),
        .issue_o     (issue_o),
        .cancel_o    (cancel_o),
        .done_o      (done_o)
    );
endmodule

// File: rtl/lcd_checker.sv
module lcd_checker #(
    parameter int NDATA = 4,
    parameter int NBLK  = 2 * NDATA
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start_i,
    input logic [NBLK-1:0] issue_o,
    input logic [NBLK-1:0] cancel_o,
    input logic            done_o,
    input logic [NBLK-1:0] got_q,
    input logic [NBLK-1:0] known_q
);
    assert_issue_whole_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|issue_o) |-> (&issue_o));

    assert_issue_after_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|issue_o) |-> $past(start_i));

    assert_no_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_o & cancel_o) == '0);

    assert_no_cancel_done_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cancel_o & got_q) == '0);

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_data_known_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (&known_q[NDATA-1:0]));
endmodule

bind lazy_cancel_dec lcd_checker #(.NDATA(NDATA), .NBLK(NBLK)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .issue_o  (issue_o),
    .cancel_o (cancel_o),
    .done_o   (done_o),
    .got_q    (got_w),
    .known_q  (known_w)
);

// File: tb/lazy_cancel_dec_tb_top.sv
`timescale 1ns/1ps
module lazy_cancel_dec_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       cpl_valid_i = 1'b0;
    logic [2:0] cpl_id_i = 3'd0;
    logic [7:0] issue_o;
    logic [7:0] cancel_o;
    logic       done_o;

    int checks = 0;
    int failures = 0;

    logic [7:0] m_known;
    logic [7:0] m_pend;
    bit         m_live = 1'b0;

    always #10 clk = ~clk;

    lazy_cancel_dec dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .cpl_valid_i (cpl_valid_i),
        .cpl_id_i    (cpl_id_i),
        .issue_o     (issue_o),
        .cancel_o    (cancel_o),
        .done_o      (done_o)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Fixed point of the ring rule: a triple with one unknown member is filled in.
    function automatic logic [7:0] close_set(input logic [7:0] k);
        logic [7:0] r;
        bit changed;
        r = k;
        changed = 1'b1;
        while (changed) begin
            changed = 1'b0;
            for (int j = 0; j < 4; j++) begin
                int miss;
                miss = (r[j] ? 0 : 1) + (r[(j + 1) % 4] ? 0 : 1) + (r[4 + j] ? 0 : 1);
                if (miss == 1) begin
                    r[j] = 1'b1; r[(j + 1) % 4] = 1'b1; r[4 + j] = 1'b1;
                    changed = 1'b1;
                end
            end
        end
        return r;
    endfunction

    // Starts a request; entered and left just after a falling edge.
    task automatic start_req();
        start_i = 1'b1;
        @(negedge clk);
        chk("R2 issue strobe", {8'h00, issue_o}, 16'h00FF);
        start_i = 1'b0;
        m_pend = 8'hFF;
        m_known = 8'h00;
        m_live = 1'b1;
        @(negedge clk);
        chk("R2 issue single cycle", {8'h00, issue_o}, 16'h0000);
    endtask

    // Sends one completion and checks cancel/done one cycle later (R5 R6 R7 R8).
    task automatic send(input logic [2:0] id, input string req);
        logic [7:0] hitv;
        logic [7:0] cl;
        logic [7:0] fresh;
        logic [7:0] exp_c;
        logic       exp_d;
        cpl_valid_i = 1'b1;
        cpl_id_i = id;
        @(negedge clk);
        cpl_valid_i = 1'b0;
        exp_c = 8'h00;
        exp_d = 1'b0;
        hitv = 8'h01 << id;
        if (m_live && m_pend[id]) begin
            cl = close_set(m_known | hitv);
            fresh = cl & ~m_known & ~hitv;
            exp_c = fresh & m_pend;
            m_pend = m_pend & ~hitv & ~fresh;
            m_known = cl;
            if (&cl[3:0]) begin
                exp_c = exp_c | m_pend;
                m_pend = 8'h00;
                exp_d = 1'b1;
                m_live = 1'b0;
            end
        end
        chk(req, {7'h00, done_o, cancel_o}, {7'h00, exp_d, exp_c});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL R7 watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int unsigned seed;
        logic [2:0] order [8];
        seed = 32'h1234_5678;
        repeat (3) @(negedge clk);
        chk("R1 reset outputs", {7'h00, done_o, issue_o | cancel_o}, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", {7'h00, done_o, issue_o | cancel_o}, 16'h0000);

        // R10: completion while idle is ignored.
        send(3'd5, "R10 idle completion ignored");
        chk("R10 no issue", {8'h00, issue_o}, 16'h0000);

        // R9 worked example, with R3 and R8 probes.
        start_req();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk("R3 start while busy", {8'h00, issue_o}, 16'h0000);
        send(3'd0, "R9 complete d0");
        chk("R9 no cancel after d0", {8'h00, cancel_o}, 16'h0000);
        send(3'd3, "R9 complete d3");
        chk("R9 parity7 cancelled", {8'h00, cancel_o}, 16'h0080);
        send(3'd6, "R9 complete parity6");
        chk("R9 d2 cancelled", {8'h00, cancel_o}, 16'h0004);
        send(3'd7, "R8 late parity7 ignored");
        send(3'd2, "R8 late d2 ignored");
        send(3'd0, "R8 repeated d0 ignored");
        send(3'd5, "R9 complete parity5");
        chk("R9 done with flush", {7'h00, done_o, cancel_o}, 16'h0112);
        @(negedge clk);
        chk("R7 back to idle", {7'h00, done_o, issue_o | cancel_o}, 16'h0000);

        // Sweep of completion orders (R4 R5 R6 R7 R8 R10).
        for (int s = 0; s < 240; s++) begin
            for (int i = 0; i < 8; i++) order[i] = 3'(i);
            for (int i = 7; i > 0; i--) begin
                int k;
                logic [2:0] t;
                seed = seed * 32'd1103515245 + 32'd12345;
                k = int'((seed >> 16) % (i + 1));
                t = order[i]; order[i] = order[k]; order[k] = t;
            end
            start_req();
            for (int i = 0; i < 8; i++) begin
                send(order[i], "R5 R6 sweep step");
                if ((s % 2) == 1 && i == 3) send(order[1], "R8 sweep repeat");
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule